// File: doc/BRIEF.md
# SPI Flash Page Program Engine

This block drives one page-program transaction to a serial NOR flash over a shared SPI bus. A single-cycle start pulse captures a 24-bit page address and a burst length. The engine then asks a bus arbiter for the shared lines and waits to be granted. Once granted, it sends one continuous serial stream: the program opcode 02h, the three address bytes, and then the data bytes.

Data bytes are pulled one at a time from a byte-wide ready/valid input. The serial clock simply stops, parked low, whenever the next byte is late. After the last bit, chip select goes high, the bus is handed back, and an external page-program delay timer is started. The engine signals completion only after that timer expires. A write-enable command must already have completed before start is pulsed; issuing it is the caller's job.

Top module: `spi_page_prog`

## Requirements
- R1: A start pulse in the idle state captures `page_addr_i` and `burst_len_i`. A start pulse at any other time is ignored, and no second transaction follows.
- R2: After start, `bus_req_o` goes high and stays high until the stream has ended. No serial clock edge occurs and chip select stays high until `bus_ack_i` has been seen.
- R3: The first 8 serial bits are the opcode 02h, most significant bit first.
- R4: The next 24 bits are the captured address, most significant bit first.
- R5: Exactly L data bytes follow, in handshake order and most significant bit first, where L is `burst_len_i`. A value of 0 means 256.
- R6: `sclk_o` idles low. Each bit is driven on `mosi_o` while `sclk_o` is low, then `sclk_o` is high for exactly one cycle with `mosi_o` unchanged.
- R7: `cs_n_o` falls once per transaction and stays low from the first opcode bit to the last data bit. `sclk_o` is never high while `cs_n_o` is high. When `cs_n_o` rises, `sclk_o` is 0 and `mosi_o` is 1.
- R8: `wr_ready_o` is high only when the data phase needs a new byte. A byte moves on a cycle where both `wr_valid_i` and `wr_ready_o` are high. While no byte is offered, `sclk_o` stays low and produces no extra edges.
- R9: When chip select rises, `bus_req_o` drops in the same cycle. The cycle after `bus_ack_i` is then seen, `tmr_start_o` is high for exactly one cycle.
- R10: `done_o` is high for exactly one cycle, in the cycle after `tmr_done_i` is seen. It is never high before that.
- R11: During and right after reset, `cs_n_o`=1, `sclk_o`=0, `mosi_o`=1, and `bus_req_o`, `wr_ready_o`, `tmr_start_o` and `done_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse for one page program |
| page_addr_i | input | 24 | Target address, captured on start |
| burst_len_i | input | 8 | Number of data bytes, 0 means 256 |
| bus_req_o | output | 1 | Request for the shared SPI lines |
| bus_ack_i | input | 1 | Arbiter acknowledge, for both grant and release |
| wr_data_i | input | 8 | Next data byte |
| wr_valid_i | input | 1 | Data byte available |
| wr_ready_o | output | 1 | Engine takes a byte this cycle if valid |
| sclk_o | output | 1 | SPI serial clock |
| cs_n_o | output | 1 | SPI chip select, active low |
| mosi_o | output | 1 | SPI serial data out |
| tmr_start_o | output | 1 | One-cycle start for the page-program delay timer |
| tmr_done_i | input | 1 | Delay timer expired |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench looks hardest at data starvation. A byte source that pauses several cycles between bytes must leave the serial bit count at exactly 32 plus 8 per byte; an engine that kept toggling the clock while waiting would add bits or repeat stale ones. A burst length of 0 must send 256 bytes; an engine that took 0 literally would stop right after the address. A start pulse in the middle of a transaction must change neither the stream nor anything after completion; a design that captured it would resend or corrupt the address. Delayed acknowledges and a late timer check that chip select, the timer start and the done pulse do not fire early and appear exactly once.

// File: rtl/spp_pkg.sv
package spp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_SHIFT,
    ST_REL,
    ST_TIMER
  } seq_state_t;

  localparam logic [7:0] OPC_PAGE_PROG = 8'h02;

endpackage

// File: rtl/spp_bit_shifter.sv
// Two-state-per-bit serializer: low phase presents the bit, high phase
// raises the clock and advances the shift register.
module spp_bit_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] byte_i,
  input  logic         park_i,
  output logic         empty_o,
  output logic         sclk_o,
  output logic         mosi_o
);

  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  sr_q, sr_n;
  logic [CW-1:0] left_q, left_n;
  logic          hi_q, hi_n;
  logic          sclk_q, sclk_n;
  logic          mosi_q, mosi_n;

  assign empty_o = !hi_q && (left_q == '0);
  assign sclk_o  = sclk_q;
  assign mosi_o  = mosi_q;

  always_comb begin
    sr_n   = sr_q;
    left_n = left_q;
    hi_n   = hi_q;
    sclk_n = 1'b0;
    mosi_n = mosi_q;
    if (load_i) begin
      sr_n   = byte_i;
      mosi_n = byte_i[W-1];
      left_n = CW'(W - 1);
      hi_n   = 1'b1;
    end else if (hi_q) begin
      sclk_n = 1'b1;
      sr_n   = {sr_q[W-2:0], 1'b0};
      hi_n   = 1'b0;
    end else if (left_q != '0) begin
      mosi_n = sr_q[W-1];
      left_n = left_q - 1'b1;
      hi_n   = 1'b1;
    end else if (park_i) begin
      mosi_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      left_q <= '0;
      hi_q   <= 1'b0;
      sclk_q <= 1'b0;
      mosi_q <= 1'b1;
    end else begin
      sr_q   <= sr_n;
      left_q <= left_n;
      hi_q   <= hi_n;
      sclk_q <= sclk_n;
      mosi_q <= mosi_n;
    end
  end

endmodule

// File: rtl/spp_byte_src.sv
// Holds the captured address and length, hands out header bytes in
// order and counts data bytes against the burst length.
module spp_byte_src #(
  parameter int          ADDR_W = 24,
  parameter int          LEN_W  = 8,
  parameter logic [7:0]  OPCODE = 8'h02
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              hdr_take_i,
  input  logic              data_take_i,
  output logic              hdr_pend_o,
  output logic              data_pend_o,
  output logic [7:0]        hdr_byte_o
);

  localparam int HDR_BYTES = 1 + ADDR_W / 8;
  localparam int HDR_W     = 8 * HDR_BYTES;
  localparam int IW        = $clog2(HDR_BYTES + 1);
  localparam int SLOTS     = 1 << IW;
  localparam int LW        = LEN_W + 1;

  logic [ADDR_W-1:0] addr_q;
  logic [LW-1:0]     len_q;
  logic [LW-1:0]     cnt_q;
  logic [IW-1:0]     idx_q;
  logic [HDR_W-1:0]  hdr_vec;
  logic [7:0]        slot [SLOTS];

  assign hdr_vec = {OPCODE, addr_q};

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    if (k < HDR_BYTES) begin : g_used
      assign slot[k] = hdr_vec[HDR_W-1-8*k -: 8];
    end else begin : g_pad
      assign slot[k] = 8'h00;
    end
  end

  assign hdr_byte_o  = slot[idx_q];
  assign hdr_pend_o  = (idx_q != IW'(HDR_BYTES));
  assign data_pend_o = (cnt_q != len_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      len_q  <= '0;
    end else if (capture_i) begin
      addr_q <= addr_i;
      len_q  <= (len_i == '0) ? LW'(1 << LEN_W) : {1'b0, len_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      cnt_q <= '0;
    end else if (capture_i) begin
      idx_q <= '0;
      cnt_q <= '0;
    end else begin
      if (hdr_take_i)  idx_q <= idx_q + 1'b1;
      if (data_take_i) cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/spp_seq.sv
// Transaction sequencer: bus request, streaming, release, timer wait.
module spp_seq
  import spp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic bus_ack_i,
  input  logic tmr_done_i,
  input  logic sh_empty_i,
  input  logic hdr_pend_i,
  input  logic data_pend_i,
  input  logic wr_valid_i,
  output logic capture_o,
  output logic load_o,
  output logic sel_data_o,
  output logic park_o,
  output logic wr_ready_o,
  output logic bus_req_o,
  output logic cs_n_o,
  output logic tmr_start_o,
  output logic done_o
);

  seq_state_t st_q, st_n;
  logic bus_req_q, bus_req_n;
  logic cs_n_q, cs_n_n;
  logic tstart_q, tstart_n;
  logic done_q, done_n;

  always_comb begin
    st_n       = st_q;
    bus_req_n  = bus_req_q;
    cs_n_n     = cs_n_q;
    tstart_n   = 1'b0;
    done_n     = 1'b0;
    capture_o  = 1'b0;
    load_o     = 1'b0;
    sel_data_o = 1'b0;
    park_o     = 1'b0;
    wr_ready_o = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          capture_o = 1'b1;
          bus_req_n = 1'b1;
          st_n      = ST_REQ;
        end
      end
      ST_REQ: begin
        if (bus_ack_i) st_n = ST_SHIFT;
      end
      ST_SHIFT: begin
        if (sh_empty_i) begin
          if (hdr_pend_i) begin
            load_o = 1'b1;
            cs_n_n = 1'b0;
          end else if (data_pend_i) begin
            wr_ready_o = 1'b1;
            if (wr_valid_i) begin
              load_o     = 1'b1;
              sel_data_o = 1'b1;
            end
          end else begin
            park_o    = 1'b1;
            cs_n_n    = 1'b1;
            bus_req_n = 1'b0;
            st_n      = ST_REL;
          end
        end
      end
      ST_REL: begin
        if (bus_ack_i) begin
          tstart_n = 1'b1;
          st_n     = ST_TIMER;
        end
      end
      ST_TIMER: begin
        if (tmr_done_i) begin
          done_n = 1'b1;
          st_n   = ST_IDLE;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      bus_req_q <= 1'b0;
      cs_n_q    <= 1'b1;
      tstart_q  <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      st_q      <= st_n;
      bus_req_q <= bus_req_n;
      cs_n_q    <= cs_n_n;
      tstart_q  <= tstart_n;
      done_q    <= done_n;
    end
  end

  assign bus_req_o   = bus_req_q;
  assign cs_n_o      = cs_n_q;
  assign tmr_start_o = tstart_q;
  assign done_o      = done_q;

endmodule

// File: rtl/spi_page_prog.sv
module spi_page_prog #(
  parameter int ADDR_W = 24,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] page_addr_i,
  input  logic [LEN_W-1:0]  burst_len_i,
  output logic              bus_req_o,
  input  logic              bus_ack_i,
  input  logic [7:0]        wr_data_i,
  input  logic              wr_valid_i,
  output logic              wr_ready_o,
  output logic              sclk_o,
  output logic              cs_n_o,
  output logic              mosi_o,
  output logic              tmr_start_o,
  input  logic              tmr_done_i,
  output logic              done_o
);

  logic       capture, load, sel_data, park;
  logic       sh_empty, hdr_pend, data_pend;
  logic [7:0] hdr_byte, load_byte;

  assign load_byte = sel_data ? wr_data_i : hdr_byte;

  spp_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .bus_ack_i   (bus_ack_i),
    .tmr_done_i  (tmr_done_i),
    .sh_empty_i  (sh_empty),
    .hdr_pend_i  (hdr_pend),
    .data_pend_i (data_pend),
    .wr_valid_i  (wr_valid_i),
    .capture_o   (capture),
    .load_o      (load),
    .sel_data_o  (sel_data),
    .park_o      (park),
    .wr_ready_o  (wr_ready_o),
    .bus_req_o   (bus_req_o),
    .cs_n_o      (cs_n_o),
    .tmr_start_o (tmr_start_o),
    .done_o      (done_o)
  );

  spp_byte_src #(
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W),
    .OPCODE (spp_pkg::OPC_PAGE_PROG)
  ) u_src (
    .clk         (clk),
    .rst_n       (rst_n),
    .capture_i   (capture),
    .addr_i      (page_addr_i),
    .len_i       (burst_len_i),
    .hdr_take_i  (load && !sel_data),
    .data_take_i (load && sel_data),
    .hdr_pend_o  (hdr_pend),
    .data_pend_o (data_pend),
    .hdr_byte_o  (hdr_byte)
  );

  spp_bit_shifter #(
    .W (8)
  ) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load),
    .byte_i  (load_byte),
    .park_i  (park),
    .empty_o (sh_empty),
    .sclk_o  (sclk_o),
    .mosi_o  (mosi_o)
  );

endmodule

// File: rtl/spi_page_prog_chk.sv
module spi_page_prog_chk (
  input logic clk,
  input logic rst_n,
  input logic bus_req_o,
  input logic wr_ready_o,
  input logic sclk_o,
  input logic cs_n_o,
  input logic mosi_o,
  input logic tmr_start_o,
  input logic done_o
);

  AST_SCLK_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_o |-> !cs_n_o); // R7

  AST_CS_RISE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n_o) |-> (!sclk_o && mosi_o)); // R7

  AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_o |-> $stable(mosi_o)); // R6

  AST_SCLK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_o |=> !sclk_o); // R6

  AST_CS_NEEDS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n_o |-> bus_req_o); // R2

  AST_READY_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready_o |-> (bus_req_o && !cs_n_o)); // R8

  AST_TSTART_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_start_o |=> !tmr_start_o); // R9

  AST_TSTART_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_start_o |-> (!bus_req_o && cs_n_o)); // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R10

endmodule

bind spi_page_prog spi_page_prog_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_req_o   (bus_req_o),
  .wr_ready_o  (wr_ready_o),
  .sclk_o      (sclk_o),
  .cs_n_o      (cs_n_o),
  .mosi_o      (mosi_o),
  .tmr_start_o (tmr_start_o),
  .done_o      (done_o)
);

// File: tb/spi_page_prog_tb.sv
module spi_page_prog_tb;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [23:0] page_addr_i;
  logic [7:0]  burst_len_i;
  logic        bus_req_o;
  logic        bus_ack_i;
  logic [7:0]  wr_data_i;
  logic        wr_valid_i;
  logic        wr_ready_o;
  logic        sclk_o;
  logic        cs_n_o;
  logic        mosi_o;
  logic        tmr_start_o;
  logic        tmr_done_i;
  logic        done_o;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  spi_page_prog u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .page_addr_i (page_addr_i),
    .burst_len_i (burst_len_i),
    .bus_req_o   (bus_req_o),
    .bus_ack_i   (bus_ack_i),
    .wr_data_i   (wr_data_i),
    .wr_valid_i  (wr_valid_i),
    .wr_ready_o  (wr_ready_o),
    .sclk_o      (sclk_o),
    .cs_n_o      (cs_n_o),
    .mosi_o      (mosi_o),
    .tmr_start_o (tmr_start_o),
    .tmr_done_i  (tmr_done_i),
    .done_o      (done_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected below 150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input logic [7:0] seed, input int i);
    return seed + 8'(i * 29) + 8'(i >> 3);
  endfunction

  // ---------------- data source ----------------
  int         feed_gen = 0;
  int         feed_len = 0;
  int         feed_gap = 0;
  logic [7:0] feed_seed = 8'h00;
  int         f_seen = 0;
  int         f_idx = 0;
  int         f_gapcnt = 0;
  bit         f_pend = 0;

  initial begin
    wr_valid_i = 1'b0;
    wr_data_i  = 8'h00;
  end

  always @(negedge clk) begin
    if (feed_gen != f_seen) begin
      f_seen     = feed_gen;
      f_idx      = 0;
      f_gapcnt   = 0;
      f_pend     = 0;
      wr_valid_i = 1'b1;
      wr_data_i  = pat(feed_seed, 0);
    end else if (f_pend) begin
      f_idx++;
      if (f_idx < feed_len) begin
        if (feed_gap > 0) begin
          wr_valid_i = 1'b0;
          f_gapcnt   = feed_gap;
        end else begin
          wr_data_i = pat(feed_seed, f_idx);
        end
      end else begin
        wr_valid_i = 1'b0;
      end
    end else if (f_gapcnt > 0) begin
      f_gapcnt--;
      if (f_gapcnt == 0) begin
        wr_valid_i = 1'b1;
        wr_data_i  = pat(feed_seed, f_idx);
      end
    end
    f_pend = wr_valid_i && wr_ready_o;
  end

  // ---------------- serial line monitor ----------------
  logic cap_bits [0:2111];
  int   cap_n = 0;
  int   cs_falls = 0;
  int   r6_err = 0;
  int   r7_err = 0;
  int   r8_err = 0;
  logic p_sclk = 1'b0;
  logic p_cs   = 1'b1;
  logic p_mosi = 1'b1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (sclk_o && !p_sclk) begin
        if (cap_n < 2112) cap_bits[cap_n] = mosi_o;
        cap_n++;
      end
      if (sclk_o && (p_sclk || mosi_o != p_mosi)) r6_err++;
      if (sclk_o && cs_n_o) r7_err++;
      if (!cs_n_o && p_cs) cs_falls++;
      if (cs_n_o && !p_cs && (sclk_o || !mosi_o)) r7_err++;
      if (wr_ready_o && cap_n < 32) r8_err++;
    end
    p_sclk = sclk_o;
    p_cs   = cs_n_o;
    p_mosi = mosi_o;
  end

  function automatic logic [7:0] cap_byte(input int b);
    logic [7:0] v = 8'h00;
    for (int j = 0; j < 8; j++) v = {v[6:0], cap_bits[8*b+j]};
    return v;
  endfunction

  // ---------------- scenarios ----------------
  task automatic t_reset();
    check(cs_n_o == 1'b1 && sclk_o == 1'b0 && mosi_o == 1'b1, "R11 line idle",
          {cs_n_o, sclk_o, mosi_o}, 3'b101);
    check(!bus_req_o && !wr_ready_o && !tmr_start_o && !done_o, "R11 controls low",
          {bus_req_o, wr_ready_o, tmr_start_o, done_o}, 0);
  endtask

  task automatic run_op(input logic [23:0] addr, input logic [7:0] len, input int gap,
                        input int ack_dly, input bit poke, input logic [7:0] seed);
    int nbytes;
    int e6, e7, e8;
    bit bad_data;
    int bad_idx;
    logic [7:0] bad_val;
    nbytes = (len == 8'd0) ? 256 : int'(len);
    e6 = r6_err; e7 = r7_err; e8 = r8_err;
    @(negedge clk);
    cap_n     = 0;
    cs_falls  = 0;
    feed_len  = nbytes;
    feed_gap  = gap;
    feed_seed = seed;
    feed_gen++;
    start_i     = 1'b1;
    page_addr_i = addr;
    burst_len_i = len;
    @(negedge clk);
    start_i     = 1'b0;
    page_addr_i = 24'h0;
    burst_len_i = 8'h0;
    check(bus_req_o == 1'b1, "R2 request raised", bus_req_o, 1);
    for (int i = 0; i < ack_dly; i++) @(negedge clk);
    check(cs_n_o == 1'b1 && cap_n == 0, "R2 no frame before ack", cap_n, 0);
    bus_ack_i = 1'b1;
    @(negedge clk);
    bus_ack_i = 1'b0;
    if (poke) begin
      for (int i = 0; i < 5; i++) @(negedge clk);
      start_i     = 1'b1;
      page_addr_i = 24'h5A5A5A;
      burst_len_i = 8'd9;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (bus_req_o) @(negedge clk);
    check(cs_n_o == 1'b1 && sclk_o == 1'b0 && mosi_o == 1'b1, "R7 end of frame",
          {cs_n_o, sclk_o, mosi_o}, 3'b101);
    check(cap_n == 32 + 8 * nbytes, "R8 bit count", cap_n, 32 + 8 * nbytes);
    check(cap_byte(0) == 8'h02, "R3 opcode", cap_byte(0), 8'h02);
    check({cap_byte(1), cap_byte(2), cap_byte(3)} == addr, "R4 address",
          {cap_byte(1), cap_byte(2), cap_byte(3)}, addr);
    bad_data = 0; bad_idx = 0; bad_val = 8'h0;
    for (int b = 0; b < nbytes; b++) begin
      if (!bad_data && cap_byte(4 + b) != pat(seed, b)) begin
        bad_data = 1; bad_idx = b; bad_val = cap_byte(4 + b);
      end
    end
    check(!bad_data, "R5 data bytes", bad_val, pat(seed, bad_idx));
    check(cs_falls == 1, "R7 one chip select window", cs_falls, 1);
    check(r6_err == e6, "R6 bit timing", r6_err - e6, 0);
    check(r7_err == e7, "R7 framing", r7_err - e7, 0);
    check(r8_err == e8, "R8 ready only in data phase", r8_err - e8, 0);
    for (int i = 0; i < ack_dly; i++) begin
      check(tmr_start_o == 1'b0, "R9 no timer before release ack", tmr_start_o, 0);
      @(negedge clk);
    end
    bus_ack_i = 1'b1;
    @(negedge clk);
    check(tmr_start_o == 1'b1, "R9 timer start", tmr_start_o, 1);
    bus_ack_i = 1'b0;
    @(negedge clk);
    check(tmr_start_o == 1'b0, "R9 timer start single", tmr_start_o, 0);
    for (int i = 0; i < 7; i++) begin
      check(done_o == 1'b0, "R10 no early done", done_o, 0);
      @(negedge clk);
    end
    tmr_done_i = 1'b1;
    @(negedge clk);
    check(done_o == 1'b1, "R10 done pulse", done_o, 1);
    tmr_done_i = 1'b0;
    @(negedge clk);
    check(done_o == 1'b0, "R10 done single", done_o, 0);
    for (int i = 0; i < 4; i++) @(negedge clk);
    check(bus_req_o == 1'b0 && cs_n_o == 1'b1, "R1 busy start ignored", bus_req_o, 0);
  endtask

  task automatic t_single();   run_op(24'h123456, 8'd1, 0, 0, 0, 8'h3C); endtask
  task automatic t_stall();    run_op(24'hA5C30F, 8'd5, 3, 6, 1, 8'h81); endtask
  task automatic t_pair();     run_op(24'h000100, 8'd2, 1, 1, 0, 8'hFF); endtask
  task automatic t_full_page(); run_op(24'hFFFF00, 8'd0, 0, 2, 0, 8'h10); endtask

  initial begin
    rst_n       = 1'b0;
    start_i     = 1'b0;
    page_addr_i = 24'h0;
    burst_len_i = 8'h0;
    bus_ack_i   = 1'b0;
    tmr_done_i  = 1'b0;
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_stall();
    t_pair();
    t_full_page();
    summary();
    $finish;
  end

endmodule